// File: doc/BRIEF.md
# Multi-Width Floating-Point Register File

This block stores thirty-two 32-bit floating-point registers and lets each port treat them as single words, even-odd pairs or aligned groups of four. Every port carries a register index and a two-bit size code. From these it moves 32, 64 or 128 bits. Load/store transfers and arithmetic results both enter through the single write port. Two independent read ports serve operand fetch and store data.

In a multi-register value, the lowest-numbered register holds the most significant word. The block checks the index against the size before it acts. A pair must start at an even index and a group of four must start at a multiple of four. The size code 11 is reserved. A write that breaks these rules is flagged and changes nothing. A read that breaks them is flagged and returns zero.

Top module: `fprf_multi_width`

## Requirements
- R1: Reset (rst_n low) clears every register to zero.
- R2: Size code 00 accesses one register at any index. A write stores wr_data[31:0]. A read returns that word in bits [31:0], with bits [127:32] zero.
- R3: Size code 01 with an even index n accesses registers n and n+1. Register n holds data bits [63:32] and register n+1 holds bits [31:0]. On a read, bits [127:64] are zero.
- R4: Size code 10 with an index n that is a multiple of four accesses registers n to n+3. Register n+k holds data bits [127-32k:96-32k]. All four registers update in the same clock cycle.
- R5: A write with size 01 and an odd index, or with size 10 and an index that is not a multiple of four, drives wr_err high in the same cycle and leaves every register unchanged.
- R6: Size code 11 is reserved. A write with this code drives wr_err high and changes no register. A read with this code drives rd_err high.
- R7: A read that is misaligned or uses size code 11 drives its rd_err bit high and returns all-zero rd_data.
- R8: The two read ports work independently and at the same time. Port p uses rd_idx[5p+4:5p], rd_size[2p+1:2p] and rd_data[128p+127:128p].
- R9: Reads are combinational. A write takes effect at the rising clock edge, so a read in the same cycle as the write returns the old contents.
- R10: While wr_en is low, no register changes and wr_err stays low, whatever index and size are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write base register index |
| wr_size | input | 2 | Write size code (00 single, 01 pair, 10 quad, 11 reserved) |
| wr_data | input | 128 | Write data, right-aligned, most significant word to lowest register |
| wr_err | output | 1 | Write rejected (misaligned or reserved size) |
| rd_idx | input | 10 | Read base indices, 5 bits per port |
| rd_size | input | 4 | Read size codes, 2 bits per port |
| rd_data | output | 256 | Read data, 128 bits per port, unused upper bits zero |
| rd_err | output | 2 | Read rejected, one bit per port |

## Verification
The bench builds the block with its default parameters: 32-bit words, thirty-two registers, two read ports and the reset-cleared storage variant. With these values, groups that end at register 31 are reachable, so the top boundary of the index space is exercised. Both read ports can be driven against each other, and a second reset after traffic shows that the reset variant clears every register. A vector table mixes aligned and misaligned writes of every size. Per-register sweeps then catch any stray update.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

   typedef enum logic [1:0] {
      FSZ_ONE  = 2'b00,
      FSZ_TWO  = 2'b01,
      FSZ_FOUR = 2'b10,
      FSZ_RSVD = 2'b11
   } fsz_e;

   localparam int LANES_MAX = 4;

endpackage

// File: rtl/fprf_size_dec.sv
module fprf_size_dec #(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [1:0]       size,
   output logic             ok,
   output logic [2:0]       nwords
);
   import fprf_pkg::*;

   always_comb begin
      ok     = 1'b0;
      nwords = 3'd0;
      case (fsz_e'(size))
         FSZ_ONE: begin
            nwords = 3'd1;
            ok     = 1'b1;
         end
         FSZ_TWO: begin
            nwords = 3'd2;
            ok     = ~idx[0];
         end
         FSZ_FOUR: begin
            nwords = 3'd4;
            ok     = (idx[1:0] == 2'b00);
         end
         default: begin
            nwords = 3'd0;
            ok     = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/fprf_read_port.sv
module fprf_read_port #(
   parameter int WORD_W   = 32,
   parameter int NUM_REGS = 32,
   parameter int IDX_W    = 5
) (
   input  logic [NUM_REGS*WORD_W-1:0]             file_i,
   input  logic [IDX_W-1:0]                       idx,
   input  logic [1:0]                             size,
   output logic [fprf_pkg::LANES_MAX*WORD_W-1:0]  rdata,
   output logic                                   rerr
);
   import fprf_pkg::*;

   logic       ok;
   logic [2:0] nw;

   fprf_size_dec #(.IDX_W(IDX_W)) u_dec (
      .idx    (idx),
      .size   (size),
      .ok     (ok),
      .nwords (nw)
   );

   assign rerr = ~ok;

   always_comb begin
      logic [IDX_W-1:0] sel;
      rdata = '0;
      sel   = '0;
      if (ok) begin
         for (int j = 0; j < LANES_MAX; j++) begin
            if (j < int'(nw)) begin
               sel = idx + IDX_W'(int'(nw) - 1 - j);
               rdata[j*WORD_W +: WORD_W] = file_i[int'(sel)*WORD_W +: WORD_W];
            end
         end
      end
   end

endmodule

// File: rtl/fprf_multi_width.sv
module fprf_multi_width #(
   parameter int WORD_W     = 32,
   parameter int NUM_REGS   = 32,
   parameter int NUM_RD     = 2,
   parameter bit RESET_FILE = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [$clog2(NUM_REGS)-1:0]         wr_idx,
   input  logic [1:0]                          wr_size,
   input  logic [4*WORD_W-1:0]                 wr_data,
   output logic                                wr_err,
   input  logic [NUM_RD*$clog2(NUM_REGS)-1:0]  rd_idx,
   input  logic [NUM_RD*2-1:0]                 rd_size,
   output logic [NUM_RD*4*WORD_W-1:0]          rd_data,
   output logic [NUM_RD-1:0]                   rd_err
);
   import fprf_pkg::*;

   localparam int IDX_W  = $clog2(NUM_REGS);
   localparam int WIDE_W = LANES_MAX * WORD_W;
   localparam int FILE_W = NUM_REGS * WORD_W;

   // elaboration-time parameter checks
   if (WORD_W < 1) begin : g_bad_word
      $error("WORD_W must be positive");
   end
   if (NUM_REGS < LANES_MAX || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("NUM_REGS must be a power of two and at least four");
   end
   if (NUM_RD < 1) begin : g_bad_rd
      $error("NUM_RD must be at least one");
   end

   logic [WORD_W-1:0] regs_q [NUM_REGS];
   logic [FILE_W-1:0] file_flat;
   logic              wr_ok;
   logic [2:0]        wr_nw;
   logic              wr_go;

   fprf_size_dec #(.IDX_W(IDX_W)) u_wdec (
      .idx    (wr_idx),
      .size   (wr_size),
      .ok     (wr_ok),
      .nwords (wr_nw)
   );

   assign wr_go  = wr_en & wr_ok;
   assign wr_err = wr_en & ~wr_ok;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam int LANE2 = 1 - (r % 2);
      localparam int LANE4 = 3 - (r % 4);
      logic              hit;
      logic [WORD_W-1:0] nxt;

      always_comb begin
         hit = 1'b0;
         nxt = wr_data[WORD_W-1:0];
         case (fsz_e'(wr_size))
            FSZ_ONE:  hit = (IDX_W'(r) == wr_idx);
            FSZ_TWO: begin
               hit = ((IDX_W'(r) >> 1) == (wr_idx >> 1));
               nxt = wr_data[LANE2*WORD_W +: WORD_W];
            end
            FSZ_FOUR: begin
               hit = ((IDX_W'(r) >> 2) == (wr_idx >> 2));
               nxt = wr_data[LANE4*WORD_W +: WORD_W];
            end
            default:  hit = 1'b0;
         endcase
         hit = hit & wr_go;
      end

      if (RESET_FILE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   regs_q[r] <= '0;
            else if (hit) regs_q[r] <= nxt;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) regs_q[r] <= nxt;
         end
      end

      assign file_flat[r*WORD_W +: WORD_W] = regs_q[r];
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      fprf_read_port #(
         .WORD_W   (WORD_W),
         .NUM_REGS (NUM_REGS),
         .IDX_W    (IDX_W)
      ) u_port (
         .file_i (file_flat),
         .idx    (rd_idx[p*IDX_W +: IDX_W]),
         .size   (rd_size[p*2 +: 2]),
         .rdata  (rd_data[p*WIDE_W +: WIDE_W]),
         .rerr   (rd_err[p])
      );

      assert_rd_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         rd_err[p] |-> (rd_data[p*WIDE_W +: WIDE_W] == '0));

      assert_single_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_size[p*2 +: 2] == 2'b00) |->
            (rd_data[p*WIDE_W + WORD_W +: WIDE_W - WORD_W] == '0));
   end

   assert_bad_write_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ok) |=> (file_flat == $past(file_flat)));

   assert_quad_misalign_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 2'b10 && wr_idx[1:0] != 2'b00) |-> wr_err);

   assert_rsvd_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 2'b11) |-> wr_err);

   assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(file_flat));

   assert_single_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 2'b00) |=>
         (regs_q[$past(wr_idx)] == $past(wr_data[WORD_W-1:0])));

endmodule

// File: tb/tb_fprf_multi_width.sv
module tb_fprf_multi_width;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         wr_en;
   logic [4:0]   wr_idx;
   logic [1:0]   wr_size;
   logic [127:0] wr_data;
   logic         wr_err;
   logic [9:0]   rd_idx;
   logic [3:0]   rd_size;
   logic [255:0] rd_data;
   logic [1:0]   rd_err;

   int checks   = 0;
   int failures = 0;
   logic [31:0] model [32];

   always #10 clk = ~clk;

   fprf_multi_width dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_size (wr_size),
      .wr_data (wr_data),
      .wr_err  (wr_err),
      .rd_idx  (rd_idx),
      .rd_size (rd_size),
      .rd_data (rd_data),
      .rd_err  (rd_err)
   );

   typedef struct packed {
      logic [4:0]   idx;
      logic [1:0]   sz;
      logic [127:0] dat;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{5'd3,  2'd0, 128'hDEAD0000_DEAD0001_DEAD0002_11111111},
      '{5'd6,  2'd1, 128'h0_0_22222222_33333333},
      '{5'd8,  2'd2, 128'h44444444_55555555_66666666_77777777},
      '{5'd5,  2'd1, 128'h0_0_BAD00001_BAD00002},
      '{5'd10, 2'd2, 128'hBAD10000_BAD10001_BAD10002_BAD10003},
      '{5'd0,  2'd3, 128'hBAD20000_BAD20001_BAD20002_BAD20003},
      '{5'd31, 2'd0, 128'h0_0_0_88888888},
      '{5'd30, 2'd1, 128'h0_0_99999999_AAAAAAAA},
      '{5'd28, 2'd2, 128'hBBBBBBBB_CCCCCCCC_DDDDDDDD_EEEEEEEE},
      '{5'd9,  2'd0, 128'h0_0_0_F0F0F0F0}
   };

   function automatic int words_of(input logic [1:0] sz);
      case (sz)
         2'd0: return 1;
         2'd1: return 2;
         2'd2: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic bit aligned(input logic [4:0] idx, input logic [1:0] sz);
      int n = words_of(sz);
      if (n == 0) return 1'b0;
      return (int'(idx) % n) == 0;
   endfunction

   function automatic logic [127:0] exp_rd(input logic [4:0] idx, input logic [1:0] sz);
      logic [127:0] res = '0;
      int n = words_of(sz);
      if (aligned(idx, sz))
         for (int j = 0; j < n; j++)
            res[j*32 +: 32] = model[int'(idx) + n - 1 - j];
      return res;
   endfunction

   task automatic model_write(input logic [4:0] idx, input logic [1:0] sz, input logic [127:0] d);
      int n = words_of(sz);
      if (aligned(idx, sz))
         for (int k = 0; k < n; k++)
            model[int'(idx) + k] = d[(n - 1 - k)*32 +: 32];
   endtask

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [4:0] idx, input logic [1:0] sz);
      if (sz == 2'd3) return "R6";
      if (!aligned(idx, sz)) return "R5";
      if (sz == 2'd0) return "R2";
      if (sz == 2'd1) return "R3";
      return "R4";
   endfunction

   task automatic sweep(input string tag);
      for (int r = 0; r < 32; r++) begin
         @(negedge clk);
         rd_idx[9:5]  = 5'(r);
         rd_size[3:2] = 2'd0;
         #1;
         chk(tag, rd_data[255:128], {96'd0, model[r]});
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_data = '0;
      rd_idx = '0; rd_size = '0;
      for (int r = 0; r < 32; r++) model[r] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: state after the first reset
      sweep("R1");

      // table of writes, each read back on port 0
      for (int v = 0; v < 10; v++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_idx = VECS[v].idx; wr_size = VECS[v].sz; wr_data = VECS[v].dat;
         #1;
         chk(tag_of(VECS[v].idx, VECS[v].sz), {127'd0, wr_err},
             {127'd0, !aligned(VECS[v].idx, VECS[v].sz)});
         @(posedge clk);
         model_write(VECS[v].idx, VECS[v].sz, VECS[v].dat);
         @(negedge clk);
         wr_en = 1'b0;
         rd_idx[4:0] = VECS[v].idx; rd_size[1:0] = VECS[v].sz;
         #1;
         chk(tag_of(VECS[v].idx, VECS[v].sz), rd_data[127:0], exp_rd(VECS[v].idx, VECS[v].sz));
         chk("R7", {127'd0, rd_err[0]}, {127'd0, !aligned(VECS[v].idx, VECS[v].sz)});
      end

      // R5: rejected writes left every register intact
      sweep("R5");

      // R8: both ports at once, different sizes
      @(negedge clk);
      rd_idx = {5'd6, 5'd8}; rd_size = {2'd1, 2'd2};
      #1;
      chk("R8", rd_data[127:0],   exp_rd(5'd8, 2'd2));
      chk("R8", rd_data[255:128], exp_rd(5'd6, 2'd1));

      // R7: misaligned pair on port 0, reserved code on port 1
      @(negedge clk);
      rd_idx = {5'd4, 5'd3}; rd_size = {2'd3, 2'd1};
      #1;
      chk("R7", {126'd0, rd_err}, {126'd0, 2'b11});
      chk("R7", rd_data[127:0], '0);
      chk("R7", rd_data[255:128], '0);

      // R9: same-cycle read sees old data, new data after the edge
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'd12; wr_size = 2'd0; wr_data = 128'h5A5A_1234;
      rd_idx[4:0] = 5'd12; rd_size[1:0] = 2'd0;
      #1;
      chk("R9", rd_data[127:0], {96'd0, model[12]});
      @(posedge clk);
      model_write(5'd12, 2'd0, 128'h5A5A_1234);
      #1;
      chk("R9", rd_data[127:0], {96'd0, model[12]});

      // R10: idle write port with bad size and live data
      @(negedge clk);
      wr_en = 1'b0; wr_idx = 5'd13; wr_size = 2'd3; wr_data = 128'hFFFF_FFFF;
      #1;
      chk("R10", {127'd0, wr_err}, '0);
      wr_size = 2'd0;
      @(negedge clk);
      rd_idx[4:0] = 5'd13; rd_size[1:0] = 2'd0;
      #1;
      chk("R10", rd_data[127:0], {96'd0, model[13]});

      // R4: quad at the top boundary after earlier overlaps
      @(negedge clk);
      rd_idx[4:0] = 5'd28; rd_size[1:0] = 2'd2;
      #1;
      chk("R4", rd_data[127:0], 128'hBBBBBBBB_CCCCCCCC_DDDDDDDD_EEEEEEEE);

      // R1: second reset after traffic
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      for (int r = 0; r < 32; r++) model[r] = '0;
      sweep("R1");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule